// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block keeps the coherence state of a few lines in one private cache that sits on a shared snooping bus. Each line has a stored tag and a two-bit state: Modified, Exclusive, Shared or Invalid. The processor side presents read, write and evict requests and holds each one until the block reports completion. The bus side does two jobs. It issues fills, invalidate broadcasts and write-backs through a simple request/grant handshake. It also watches reads and invalidates from other agents and answers them the same cycle with a shared indication or an abort that makes the requester back off and retry.

The data array, the memory model, the replacement choice and bus arbitration lie outside the block. The way to fill on a miss comes in with each request. Grants and the shared response during a fill come from outside. A snooped read that finds a dirty line is aborted. The line is then written back and kept as Shared. A write to a Shared line waits until its invalidate broadcast has been granted.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: a request to any tag (including the reset tag value 0) gives cpu_hit low and no completion in its first cycle, and bus_req is low.
- R2: A read (req_op 00) whose tag is held in Modified, Exclusive or Shared gives cpu_hit and cpu_done in the cycle it is presented, with no bus request.
- R3: A read miss issues a fill (bus_cmd 00, bus_tag = req_tag) the next cycle into way req_way. The line is installed Exclusive if bus_shared_in is low at the grant and Shared if it is high. The request completes the cycle after the grant.
- R4: A write (req_op 01) to a Modified or Exclusive line completes in its first cycle without bus traffic, and the line is Modified afterwards.
- R5: A write to a Shared line first issues an invalidate broadcast (bus_cmd 01). After its grant the line is Modified and the write completes one cycle later. A write miss performs a fill first and then follows the rule for the state that was installed.
- R6: Eviction (req_op 10) of a clean line makes it Invalid at once with no bus traffic. Eviction of a Modified line issues a write-back (bus_cmd 10) and completes the cycle after the grant. A miss whose chosen way holds a Modified line writes that line back before the fill. An evict to an absent tag completes at once.
- R7: A snooped read (snp_op 00) hitting a Modified line raises snp_abort in the same cycle. The next cycle the block requests a write-back of that tag, and the line becomes Shared when that write-back is granted.
- R8: A snooped read hitting an Exclusive or Shared line raises snp_shared_out in the same cycle, without abort. An Exclusive line becomes Shared.
- R9: A snooped invalidate (snp_op 01) hitting a Shared line makes it Invalid.
- R10: A snoop-triggered write-back takes the bus before local traffic. A local request to that line stalls (cpu_stall high, cpu_done low) until the write-back is granted.
- R11: req_op 11 completes at once with cpu_hit low and no change. Snoop codes 10 and 11, and snoops to tags not present, give neither abort nor shared and change no line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request, held until cpu_done |
| req_op | input | 2 | 00 read, 01 write, 10 evict, 11 no operation |
| req_tag | input | TAGW | Line tag of the request |
| req_way | input | WAYW | Way to fill if the request misses |
| cpu_hit | output | 1 | Tag present in a valid state (idle, legal op) |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request pending and not completing |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 00 fill read, 01 invalidate, 10 write-back |
| bus_tag | output | TAGW | Tag of the requested transaction |
| bus_gnt | input | 1 | Grant; the transaction completes on this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at fill grant) |
| snp_valid | input | 1 | Snooped transaction from another agent |
| snp_op | input | 2 | 00 read, 01 invalidate, others ignored |
| snp_tag | input | TAGW | Snooped tag |
| snp_abort | output | 1 | Back off: dirty line will be written back |
| snp_shared_out | output | 1 | This cache keeps a clean copy |

## Verification
Completion, hit, abort and shared responses are combinational, so the bench samples them mid-cycle, after driving on the falling edge. It samples the outputs in the cycle the stimulus is applied. State changes take effect at the next rising edge. Bus requests therefore show up one cycle after the decision, and completion one cycle after a grant. The stimulus table fixes the exact cycle count for each local operation and the set of bus commands seen. The directed snoop tests sample the write-back request and the local stall in the cycles that follow an abort.

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl #(
  parameter int NLINES = 4,
  parameter int TAGW = 8,
  localparam int WAYW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [TAGW-1:0] req_tag,
  input  logic [WAYW-1:0] req_way,
  output logic            cpu_hit,
  output logic            cpu_done,
  output logic            cpu_stall,
  output logic            bus_req,
  output logic [1:0]      bus_cmd,
  output logic [TAGW-1:0] bus_tag,
  input  logic            bus_gnt,
  input  logic            bus_shared_in,
  input  logic            snp_valid,
  input  logic [1:0]      snp_op,
  input  logic [TAGW-1:0] snp_tag,
  output logic            snp_abort,
  output logic            snp_shared_out
);
  localparam logic [1:0] LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_NOP = 2'd3;
  localparam logic [1:0] BC_RD = 2'd0, BC_INV = 2'd1, BC_WB = 2'd2;

  typedef enum logic [1:0] {F_IDLE, F_FILL, F_UPG, F_LWB} fsm_t;

  logic [1:0]      st [NLINES];
  logic [TAGW-1:0] tg [NLINES];
  fsm_t            fsm, nxt;
  logic [WAYW-1:0] cur_way, nway, swb_way;
  logic            swb_pend;

  logic            r_hit, s_hit;
  logic [WAYW-1:0] r_way, s_way;
  logic [1:0]      r_st, s_st, c_st;

  always_comb begin
    r_hit = 1'b0; r_way = '0;
    s_hit = 1'b0; s_way = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (st[i] != LS_I && tg[i] == req_tag) begin r_hit = 1'b1; r_way = WAYW'(i); end
      if (st[i] != LS_I && tg[i] == snp_tag) begin s_hit = 1'b1; s_way = WAYW'(i); end
    end
  end

  assign r_st = st[r_way];
  assign s_st = st[s_way];
  assign c_st = st[cur_way];

  logic snp_rd, snp_inv, snp_act;
  assign snp_rd  = snp_valid && snp_op == 2'b00;
  assign snp_inv = snp_valid && snp_op == 2'b01;
  assign snp_act = snp_rd || snp_inv;

  assign snp_abort      = snp_rd && s_hit && s_st == LS_M;
  assign snp_shared_out = snp_rd && s_hit && (s_st == LS_E || s_st == LS_S);

  logic blk_idle, blk_busy;
  assign blk_idle = (snp_act && s_hit && r_hit && s_way == r_way) ||
                    (swb_pend && r_hit && swb_way == r_way);
  assign blk_busy = snp_act && s_hit && s_way == cur_way;

  logic upg_lost, lwb_clean;
  assign upg_lost  = fsm == F_UPG && c_st != LS_S;
  assign lwb_clean = fsm == F_LWB && c_st != LS_M;

  logic loc_req, loc_gnt, swb_gnt;
  assign loc_req = fsm != F_IDLE && !swb_pend && !blk_busy && !upg_lost && !lwb_clean;
  assign loc_gnt = loc_req && bus_gnt;
  assign swb_gnt = swb_pend && bus_gnt;

  assign bus_req = swb_pend || loc_req;
  always_comb begin
    if (swb_pend) begin
      bus_cmd = BC_WB; bus_tag = tg[swb_way];
    end else if (fsm == F_FILL) begin
      bus_cmd = BC_RD; bus_tag = req_tag;
    end else if (fsm == F_UPG) begin
      bus_cmd = BC_INV; bus_tag = tg[cur_way];
    end else begin
      bus_cmd = BC_WB; bus_tag = tg[cur_way];
    end
  end

  logic done, set_m, set_i;
  always_comb begin
    done = 1'b0; set_m = 1'b0; set_i = 1'b0;
    nxt = fsm; nway = cur_way;
    case (fsm)
      F_IDLE: if (req_valid && !blk_idle) begin
        if (req_op == OP_NOP) done = 1'b1;
        else if (req_op == OP_EV) begin
          if (!r_hit) done = 1'b1;
          else if (r_st == LS_M) begin nxt = F_LWB; nway = r_way; end
          else begin set_i = 1'b1; done = 1'b1; end
        end else if (r_hit) begin
          if (req_op == OP_RD) done = 1'b1;
          else if (r_st == LS_S) begin nxt = F_UPG; nway = r_way; end
          else begin done = 1'b1; set_m = 1'b1; end
        end else if (st[req_way] == LS_M) begin
          nxt = F_LWB; nway = req_way;
        end else begin
          nxt = F_FILL; nway = req_way;
        end
      end
      F_FILL: if (loc_gnt) nxt = F_IDLE;
      F_UPG:  if (upg_lost || loc_gnt) nxt = F_IDLE;
      F_LWB:  if (lwb_clean || loc_gnt) nxt = F_IDLE;
      default: nxt = F_IDLE;
    endcase
  end

  assign cpu_done  = done;
  assign cpu_hit   = req_valid && fsm == F_IDLE && req_op != OP_NOP && r_hit;
  assign cpu_stall = req_valid && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st[i] <= LS_I;
        tg[i] <= '0;
      end
      fsm <= F_IDLE;
      cur_way <= '0;
      swb_pend <= 1'b0;
      swb_way <= '0;
    end else begin
      fsm <= nxt;
      cur_way <= nway;
      if (set_m) st[r_way] <= LS_M;
      if (set_i) st[r_way] <= LS_I;
      if (fsm == F_FILL && loc_gnt) begin
        tg[cur_way] <= req_tag;
        st[cur_way] <= bus_shared_in ? LS_S : LS_E;
      end
      if (fsm == F_UPG && loc_gnt) st[cur_way] <= LS_M;
      if (lwb_clean || (fsm == F_LWB && loc_gnt)) st[cur_way] <= LS_I;
      if (swb_gnt) begin
        st[swb_way] <= LS_S;
        swb_pend <= 1'b0;
      end
      if (snp_abort && !swb_pend) begin
        swb_pend <= 1'b1;
        swb_way <= s_way;
      end
      if (snp_shared_out && s_st == LS_E) st[s_way] <= LS_S;
      if (snp_inv && s_hit && s_st == LS_S) st[s_way] <= LS_I;
    end
  end
endmodule

module mesi_line_ctrl_chk #(
  parameter int WAYW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            cpu_done,
  input logic            cpu_stall,
  input logic            bus_req,
  input logic [1:0]      bus_cmd,
  input logic            snp_abort,
  input logic            snp_shared_out,
  input logic            swb_pend,
  input logic [WAYW-1:0] swb_way,
  input logic            r_hit,
  input logic [WAYW-1:0] r_way
);
  assert_abort_starts_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort && !bus_req |=> bus_req && bus_cmd == 2'b10);

  assert_abort_or_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snp_abort, snp_shared_out}));

  assert_stall_behind_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    swb_pend && req_valid && r_hit && r_way == swb_way |-> !cpu_done && cpu_stall);

  assert_done_only_on_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> req_valid && !cpu_stall);

  assert_legal_bus_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_cmd != 2'b11);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.WAYW(WAYW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cpu_done(cpu_done),
  .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .snp_abort(snp_abort), .snp_shared_out(snp_shared_out),
  .swb_pend(swb_pend), .swb_way(swb_way), .r_hit(r_hit), .r_way(r_way)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_tag = 8'd0;
  logic [1:0] req_way = 2'd0;
  logic       cpu_hit, cpu_done, cpu_stall;
  logic       bus_req;
  logic [1:0] bus_cmd;
  logic [7:0] bus_tag;
  logic       bus_gnt = 1'b0;
  logic       bus_shared_in = 1'b0;
  logic       snp_valid = 1'b0;
  logic [1:0] snp_op = 2'd0;
  logic [7:0] snp_tag = 8'd0;
  logic       snp_abort, snp_shared_out;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mesi_line_ctrl #(.NLINES(4), .TAGW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_tag(req_tag), .req_way(req_way), .cpu_hit(cpu_hit), .cpu_done(cpu_done),
    .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_tag(bus_tag),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .snp_valid(snp_valid),
    .snp_op(snp_op), .snp_tag(snp_tag), .snp_abort(snp_abort),
    .snp_shared_out(snp_shared_out)
  );

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // op, tag, way, shared-at-fill, first-cycle hit, cycles to done, bus cmd mask
  // mask bit0 = fill read, bit1 = invalidate, bit2 = write-back
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 8'h10, 2'd0, 1'b0, 1'b0, 4'd3, 3'd1},  // R3 read miss -> E
    {2'd0, 8'h10, 2'd0, 1'b0, 1'b1, 4'd1, 3'd0},  // R2 read hit
    {2'd1, 8'h10, 2'd0, 1'b0, 1'b1, 4'd1, 3'd0},  // R4 write E -> M
    {2'd1, 8'h10, 2'd0, 1'b0, 1'b1, 4'd1, 3'd0},  // R4 write M
    {2'd0, 8'h20, 2'd1, 1'b1, 1'b0, 4'd3, 3'd1},  // R3 fill as S
    {2'd1, 8'h20, 2'd1, 1'b0, 1'b1, 4'd3, 3'd2},  // R5 write S: invalidate
    {2'd2, 8'h20, 2'd1, 1'b0, 1'b1, 4'd3, 3'd4},  // R6 evict dirty
    {2'd0, 8'h20, 2'd1, 1'b0, 1'b0, 4'd3, 3'd1},  // R6 gone after evict
    {2'd2, 8'h20, 2'd1, 1'b0, 1'b1, 4'd1, 3'd0},  // R6 evict clean
    {2'd1, 8'h30, 2'd2, 1'b0, 1'b0, 4'd3, 3'd1},  // R5 write miss, fill E
    {2'd1, 8'h40, 2'd3, 1'b1, 1'b0, 4'd5, 3'd3},  // R5 write miss, fill S then inv
    {2'd0, 8'h50, 2'd2, 1'b0, 1'b0, 4'd5, 3'd5},  // R6 dirty victim written back
    {2'd0, 8'h30, 2'd1, 1'b1, 1'b0, 4'd3, 3'd1},  // R3 refill as S
    {2'd3, 8'h10, 2'd0, 1'b0, 1'b0, 4'd1, 3'd0},  // R11 no-op code
    {2'd1, 8'h10, 2'd0, 1'b0, 1'b1, 4'd1, 3'd0},  // R11 line still M
    {2'd2, 8'h99, 2'd0, 1'b0, 1'b0, 4'd1, 3'd0}   // R6 evict absent tag
  };

  task automatic run_op(input logic [1:0] op, input logic [7:0] tag, input logic [1:0] way,
                        input logic shr, output int hit1, output int cyc, output int mask);
    bit first = 1'b1;
    bit fin = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_tag = tag; req_way = way;
    cyc = 0; mask = 0; hit1 = 0;
    while (!fin && cyc < 40) begin
      #5;
      if (first) hit1 = int'(cpu_hit);
      first = 1'b0;
      cyc++;
      if (cpu_done) fin = 1'b1;
      else if (bus_req) begin
        mask = mask | (1 << bus_cmd);
        bus_gnt = 1'b1;
        bus_shared_in = shr;
      end
      @(negedge clk);
      bus_gnt = 1'b0;
      bus_shared_in = 1'b0;
    end
    req_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [7:0] tag, output int ab, output int sh);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_tag = tag;
    #5;
    ab = int'(snp_abort); sh = int'(snp_shared_out);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int h, c, m, ab, sh;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_tag = 8'h00;
    #5;
    check("R1 hit after reset", int'(cpu_hit), 0);
    check("R1 done after reset", int'(cpu_done), 0);
    check("R1 bus_req after reset", int'(bus_req), 0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    check("R1 bus_req idle", int'(bus_req), 0);

    for (int k = 0; k < NV; k++) begin
      run_op(VEC[k][20:19], VEC[k][18:11], VEC[k][10:9], VEC[k][8], h, c, m);
      check($sformatf("R2-table row %0d hit", k), h, int'(VEC[k][7]));
      check($sformatf("R3-table row %0d cycles", k), c, int'(VEC[k][6:3]));
      check($sformatf("R5-table row %0d bus cmds", k), m, int'(VEC[k][2:0]));
    end

    // R8: read snoop on Exclusive 0x50
    snoop(2'd0, 8'h50, ab, sh);
    check("R8 abort on E", ab, 0);
    check("R8 shared on E", sh, 1);
    run_op(2'd1, 8'h50, 2'd2, 1'b0, h, c, m);
    check("R8 E became S: cycles", c, 3);
    check("R8 E became S: invalidate", m, 2);

    // R9: read snoop on Shared then invalidate
    snoop(2'd0, 8'h30, ab, sh);
    check("R8 shared on S", sh, 1);
    check("R8 abort on S", ab, 0);
    snoop(2'd1, 8'h30, ab, sh);
    check("R9 invalidate outputs", ab + sh, 0);
    run_op(2'd0, 8'h30, 2'd1, 1'b0, h, c, m);
    check("R9 line invalid: hit", h, 0);
    check("R9 line invalid: refill", m, 1);

    // R7/R10: read snoop on Modified 0x10
    snoop(2'd0, 8'h10, ab, sh);
    check("R7 abort on M", ab, 1);
    check("R7 shared on M", sh, 0);
    req_valid = 1'b1; req_op = 2'd0; req_tag = 8'h10; req_way = 2'd0;
    #5;
    check("R7 wb requested", int'(bus_req), 1);
    check("R7 wb cmd", int'(bus_cmd), 2);
    check("R7 wb tag", int'(bus_tag), 'h10);
    check("R10 local stalls", int'(cpu_stall), 1);
    check("R10 local not done", int'(cpu_done), 0);
    @(negedge clk);
    #5;
    check("R10 still stalled", int'(cpu_done), 0);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    #5;
    check("R10 done after wb", int'(cpu_done), 1);
    check("R10 hit after wb", int'(cpu_hit), 1);
    check("R7 no further bus", int'(bus_req), 0);
    @(negedge clk);
    req_valid = 1'b0;
    run_op(2'd1, 8'h10, 2'd0, 1'b0, h, c, m);
    check("R7 line Shared: cycles", c, 3);
    check("R7 line Shared: invalidate", m, 2);

    // R11: illegal snoop code and absent tag
    snoop(2'd2, 8'h40, ab, sh);
    check("R11 bad snoop outputs", ab + sh, 0);
    run_op(2'd1, 8'h40, 2'd3, 1'b0, h, c, m);
    check("R11 M kept: cycles", c, 1);
    check("R11 M kept: no bus", m, 0);
    snoop(2'd1, 8'h77, ab, sh);
    check("R11 absent snoop outputs", ab + sh, 0);
    snoop(2'd0, 8'h77, ab, sh);
    check("R11 absent read snoop", ab + sh, 0);
    run_op(2'd0, 8'h50, 2'd2, 1'b0, h, c, m);
    check("R2 hit unaffected", h, 1);
    check("R2 one cycle", c, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule